// File: doc/BRIEF.md
# Model-Specific Register Write Unit

This block carries out the write-to-model-specific-register operation for a simple processor model. One request carries a register index, two 64-bit source operands whose low halves form the 64-bit value, the current privilege level, the execution mode flags and a lock-prefix flag. The unit decodes the index against a small built-in table of implemented registers. It then runs a chain of fault checks. If every check passes, it commits the value. Otherwise it reports exactly one fault.

Requests arrive on a valid/ready stream. `req_ready` is held high, so the unit never applies back-pressure and takes a request on every clock edge where `req_valid` is high. The response is a plain status pulse (`rsp_valid`) one cycle later. It carries the fault code, a serialize request and a TLB-flush request. The flush request also covers global entries. The response cannot be stalled. A combinational debug port returns the stored contents of any implemented register.

Top module: `msr_write_unit`

## Requirements
- R1: The committed value is `req_hi[31:0]` in bits 63:32 and `req_lo[31:0]` in bits 31:0. Bits 63:32 of both operands are ignored.
- R2: Only `req_idx[31:0]` selects the register. `req_idx[63:32]` is ignored.
- R3: When `lock_prefix` is set, the fault is invalid-opcode (`rsp_fault` = 2). This fault outranks every other fault.
- R4: When not in real mode and `cpl` is nonzero, the fault is general-protection (`rsp_fault` = 1). In real mode any `cpl` is allowed.
- R5: When `mode_v86` is set, the fault is always general-protection, whatever the privilege level or real flag.
- R6: An index outside the implemented set gives a general-protection fault. The implemented set is 0x10, 0x1B, 0x200, 0x201, 0x6E0, 0x808, 0xC0000082 and 0xC0000100.
- R7: A value that sets a reserved bit gives a general-protection fault. The reserved masks are:
  - 0x1B: 0xFFFFFFF0000002FF
  - 0x200: 0xFFFFFFF000000F00
  - 0x201: 0xFFFFFFF0000007FF
  - 0x808: 0xFFFFFFFFFFFFFF00
  - all other implemented registers: none
- R8: For 0xC0000082 and 0xC0000100, a value whose bits 63:47 are not all equal gives a general-protection fault.
- R9: A successful write asserts `rsp_serialize`, except for index 0x6E0 and for any index from 0x802 through 0x83F.
- R10: A successful write to 0x200 or 0x201 (memory-type-range registers) asserts `rsp_tlb_flush`.
- R11: Any fault leaves every register unchanged and keeps `rsp_serialize` and `rsp_tlb_flush` low.
- R12: `req_ready` is always 1. `rsp_valid` is high exactly in the cycle after an accepted request. When `rsp_valid` is low, all response fields are 0 (`rsp_fault` 0 means no fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high; unit accepts every cycle |
| req_idx | input | 64 | Register index operand (low 32 bits used) |
| req_hi | input | 64 | High-half source operand (low 32 bits used) |
| req_lo | input | 64 | Low-half source operand (low 32 bits used) |
| cpl | input | 2 | Current privilege level |
| mode_real | input | 1 | Real-address mode |
| mode_v86 | input | 1 | Virtual-8086 mode |
| mode_long | input | 1 | Long mode flag (no effect on the checks) |
| lock_prefix | input | 1 | Instruction carried a lock prefix |
| dbg_idx | input | 32 | Debug read index |
| dbg_data | output | 64 | Stored value at `dbg_idx`, 0 if not implemented |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 2 | 0 none, 1 general-protection, 2 invalid-opcode |
| rsp_serialize | output | 1 | Serialize request |
| rsp_tlb_flush | output | 1 | TLB flush including global entries |

## Verification
On every cycle, the assertions check the following:
- the response timing and the quiet state between responses;
- that a lock prefix always yields invalid-opcode and virtual-8086 mode always yields general-protection;
- that the non-serializing index ranges never raise serialize;
- that a faulted response carries no side effect;
- that a register holds its value when it is not written.

Only the directed scenarios can show the rest:
- the value assembly from the operand halves;
- the exact reserved masks and the canonical boundary;
- the relative priority of faults below the lock check;
- that the flush fires on the range registers alone.

// File: rtl/msr_wr_pkg.sv
package msr_wr_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2
  } fault_e;

  localparam int unsigned IDX_W     = 32;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned VA_BITS   = 48;
  localparam int unsigned NUM_SLOTS = 8;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rsvd;
    logic              canon;
    logic              range_reg;
  } slot_desc_t;

  // Table of implemented registers.
  function automatic slot_desc_t slot_desc(input int unsigned s);
    slot_desc_t d;
    d = '0;
    case (s)
      0: d = '{32'h0000_0010, 64'h0, 1'b0, 1'b0};
      1: d = '{32'h0000_001B, 64'hFFFF_FFF0_0000_02FF, 1'b0, 1'b0};
      2: d = '{32'h0000_0200, 64'hFFFF_FFF0_0000_0F00, 1'b0, 1'b1};
      3: d = '{32'h0000_0201, 64'hFFFF_FFF0_0000_07FF, 1'b0, 1'b1};
      4: d = '{32'h0000_06E0, 64'h0, 1'b0, 1'b0};
      5: d = '{32'h0000_0808, 64'hFFFF_FFFF_FFFF_FF00, 1'b0, 1'b0};
      6: d = '{32'hC000_0082, 64'h0, 1'b1, 1'b0};
      7: d = '{32'hC000_0100, 64'h0, 1'b1, 1'b0};
      default: d = '0;
    endcase
    return d;
  endfunction

  function automatic logic skips_serialize(input logic [IDX_W-1:0] idx);
    return (idx == 32'h0000_06E0) ||
           ((idx >= 32'h0000_0802) && (idx <= 32'h0000_083F));
  endfunction

endpackage

// File: rtl/msr_index_decode.sv
module msr_index_decode
  import msr_wr_pkg::*;
#(
  parameter int unsigned SLOTS  = NUM_SLOTS,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [IDX_W-1:0]  idx,
  output logic              hit,
  output logic [SLOT_W-1:0] slot,
  output logic [DATA_W-1:0] rsvd_mask,
  output logic              canon_req,
  output logic              range_reg
);
  logic [SLOTS-1:0] match;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match[g] = (idx == slot_desc(g).idx);
  end

  always_comb begin
    hit       = 1'b0;
    slot      = '0;
    rsvd_mask = '0;
    canon_req = 1'b0;
    range_reg = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (match[s] && !hit) begin
        hit       = 1'b1;
        slot      = SLOT_W'(s);
        rsvd_mask = slot_desc(s).rsvd;
        canon_req = slot_desc(s).canon;
        range_reg = slot_desc(s).range_reg;
      end
    end
  end
endmodule

// File: rtl/msr_fault_check.sv
module msr_fault_check
  import msr_wr_pkg::*;
(
  input  logic              lock_prefix,
  input  logic [1:0]        cpl,
  input  logic              mode_real,
  input  logic              mode_v86,
  input  logic              idx_hit,
  input  logic [DATA_W-1:0] rsvd_mask,
  input  logic              canon_req,
  input  logic [DATA_W-1:0] value,
  output fault_e            fault
);
  logic mode_bad, rsvd_bad, canon_bad;
  logic [DATA_W-VA_BITS:0] top_bits;

  assign top_bits  = value[DATA_W-1:VA_BITS-1];
  assign mode_bad  = mode_v86 || (!mode_real && (cpl != 2'd0));
  assign rsvd_bad  = |(value & rsvd_mask);
  assign canon_bad = canon_req && !((&top_bits) || !(|top_bits));

  // Priority: invalid opcode, mode/privilege, index, reserved, canonical.
  always_comb begin
    if (lock_prefix)   fault = FLT_UD;
    else if (mode_bad) fault = FLT_GP;
    else if (!idx_hit) fault = FLT_GP;
    else if (rsvd_bad) fault = FLT_GP;
    else if (canon_bad) fault = FLT_GP;
    else               fault = FLT_NONE;
  end
endmodule

// File: rtl/msr_reg_file.sv
module msr_reg_file
  import msr_wr_pkg::*;
#(
  parameter int unsigned SLOTS  = NUM_SLOTS,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_hit,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                               mem[g] <= '0;
      else if (wr_en && (wr_slot == SLOT_W'(g))) mem[g] <= wr_data;
    end

    AST_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_slot == SLOT_W'(g))) |=> $stable(mem[g])); // R11
  end

  assign rd_data = rd_hit ? mem[rd_slot] : '0;
endmodule

// File: rtl/msr_write_unit.sv
module msr_write_unit
  import msr_wr_pkg::*;
#(
  parameter int unsigned SLOTS  = NUM_SLOTS,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_idx,
  input  logic [63:0] req_hi,
  input  logic [63:0] req_lo,
  input  logic [1:0]  cpl,
  input  logic        mode_real,
  input  logic        mode_v86,
  input  logic        mode_long,
  input  logic        lock_prefix,
  input  logic [31:0] dbg_idx,
  output logic [63:0] dbg_data,
  output logic        rsp_valid,
  output logic [1:0]  rsp_fault,
  output logic        rsp_serialize,
  output logic        rsp_tlb_flush
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] value, rsvd_mask, dbg_mask_nc;
  logic              hit, canon_req, range_reg, commit;
  logic              dbg_hit, dbg_canon_nc, dbg_range_nc;
  logic [SLOT_W-1:0] slot, dbg_slot;
  fault_e            fault;
  logic              unused_bits;

  assign unused_bits = ^{req_idx[63:32], req_hi[63:32], req_lo[63:32], mode_long,
                         dbg_mask_nc, dbg_canon_nc, dbg_range_nc};

  assign req_ready = 1'b1;
  assign idx       = req_idx[31:0];
  assign value     = {req_hi[31:0], req_lo[31:0]};

  msr_index_decode #(.SLOTS(SLOTS)) u_wr_dec (
    .idx(idx), .hit(hit), .slot(slot), .rsvd_mask(rsvd_mask),
    .canon_req(canon_req), .range_reg(range_reg));

  msr_index_decode #(.SLOTS(SLOTS)) u_rd_dec (
    .idx(dbg_idx), .hit(dbg_hit), .slot(dbg_slot), .rsvd_mask(dbg_mask_nc),
    .canon_req(dbg_canon_nc), .range_reg(dbg_range_nc));

  msr_fault_check u_chk (
    .lock_prefix(lock_prefix), .cpl(cpl), .mode_real(mode_real),
    .mode_v86(mode_v86), .idx_hit(hit), .rsvd_mask(rsvd_mask),
    .canon_req(canon_req), .value(value), .fault(fault));

  assign commit = req_valid && (fault == FLT_NONE);

  msr_reg_file #(.SLOTS(SLOTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_slot(slot),
    .wr_data(value), .rd_hit(dbg_hit), .rd_slot(dbg_slot), .rd_data(dbg_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_fault     <= FLT_NONE;
      rsp_serialize <= 1'b0;
      rsp_tlb_flush <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_fault     <= req_valid ? fault : FLT_NONE;
      rsp_serialize <= commit && !skips_serialize(idx);
      rsp_tlb_flush <= commit && range_reg;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_fault == 2'd0) && !rsp_serialize && !rsp_tlb_flush); // R12
  AST_LOCK_UD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && lock_prefix |=> rsp_valid && (rsp_fault == 2'd2)); // R3
  AST_V86_GP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !lock_prefix && mode_v86 |=> rsp_fault == 2'd1); // R5
  AST_NOSER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ((req_idx[31:0] == 32'h6E0) ||
                  (req_idx[31:0] >= 32'h802 && req_idx[31:0] <= 32'h83F))
    |=> !rsp_serialize); // R9
  AST_FAULT_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 2'd0) |-> !rsp_serialize && !rsp_tlb_flush); // R11
endmodule

// File: tb/msr_write_unit_tb_top.sv
module msr_write_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [63:0] req_idx = 0, req_hi = 0, req_lo = 0;
  logic [1:0] cpl = 0;
  logic mode_real = 0, mode_v86 = 0, mode_long = 1, lock_prefix = 0;
  logic [31:0] dbg_idx = 0;
  logic [63:0] dbg_data;
  logic rsp_valid, rsp_serialize, rsp_tlb_flush;
  logic [1:0] rsp_fault;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msr_write_unit dut_i (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [63:0] idx, logic [63:0] hi, logic [63:0] lo,
                       logic [1:0] pl, logic rm, logic v86, logic lk);
    @(negedge clk);
    req_idx = idx; req_hi = hi; req_lo = lo; cpl = pl;
    mode_real = rm; mode_v86 = v86; lock_prefix = lk; req_valid = 1;
    @(negedge clk);
    req_valid = 0; lock_prefix = 0; mode_v86 = 0; mode_real = 0; cpl = 0;
  endtask

  task automatic expect_rsp(string req, logic [1:0] f, logic ser, logic tlb);
    check({req, " valid"}, {63'd0, rsp_valid}, 64'd1);
    check({req, " fault"}, {62'd0, rsp_fault}, {62'd0, f});
    check({req, " serialize"}, {63'd0, rsp_serialize}, {63'd0, ser});
    check({req, " tlb"}, {63'd0, rsp_tlb_flush}, {63'd0, tlb});
  endtask

  task automatic peek(string req, logic [31:0] idx, logic [63:0] exp);
    dbg_idx = idx; #1;
    check(req, dbg_data, exp);
  endtask

  task automatic t_reset;
    check("R12 reset valid", {63'd0, rsp_valid}, 0);
    check("R12 ready", {63'd0, req_ready}, 1);
    peek("R11 reset contents", 32'h10, 64'd0);
  endtask

  task automatic t_basic;
    issue({32'hDEAD_BEEF, 32'h10}, {32'hFFFF_FFFF, 32'h1234_5678},
          {32'hAAAA_AAAA, 32'h9ABC_DEF0}, 0, 0, 0, 0);
    expect_rsp("R1 R2 R9 basic", 0, 1, 0);
    peek("R1 R2 value", 32'h10, 64'h1234_5678_9ABC_DEF0);
    @(negedge clk);
    check("R12 pulse ends", {63'd0, rsp_valid}, 0);
  endtask

  task automatic t_lock;
    issue(64'h11, 0, 64'h5, 3, 0, 1, 1);
    expect_rsp("R3 lock outranks", 2, 0, 0);
    issue(64'h10, 0, 64'h5, 0, 0, 0, 1);
    expect_rsp("R3 lock", 2, 0, 0);
    peek("R11 lock no commit", 32'h10, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_priv;
    issue(64'h10, 0, 64'h77, 3, 0, 0, 0);
    expect_rsp("R4 cpl3", 1, 0, 0);
    peek("R11 cpl3 no commit", 32'h10, 64'h1234_5678_9ABC_DEF0);
    issue(64'h10, 0, 64'h77, 3, 1, 0, 0);
    expect_rsp("R4 real any cpl", 0, 1, 0);
    peek("R4 real commit", 32'h10, 64'h77);
  endtask

  task automatic t_v86;
    issue(64'h10, 0, 64'h99, 0, 1, 1, 0);
    expect_rsp("R5 v86", 1, 0, 0);
    peek("R5 no commit", 32'h10, 64'h77);
  endtask

  task automatic t_badidx;
    issue(64'h11, 0, 0, 0, 0, 0, 0);
    expect_rsp("R6 unimplemented", 1, 0, 0);
    issue(64'h83F, 0, 0, 0, 0, 0, 0);
    expect_rsp("R6 unimplemented x2", 1, 0, 0);
  endtask

  task automatic t_rsvd;
    issue(64'h1B, 0, 64'h1, 0, 0, 0, 0);
    expect_rsp("R7 low reserved", 1, 0, 0);
    issue(64'h1B, 64'h10, 64'h0, 0, 0, 0, 0);
    expect_rsp("R7 high reserved", 1, 0, 0);
    peek("R7 no commit", 32'h1B, 64'd0);
    issue(64'h1B, 64'hF, 64'h800, 0, 0, 0, 0);
    expect_rsp("R7 legal", 0, 1, 0);
    peek("R7 committed", 32'h1B, 64'h0000_000F_0000_0800);
  endtask

  task automatic t_canon;
    issue(64'hC000_0100, 64'h0000_8000, 0, 0, 0, 0, 0);
    expect_rsp("R8 noncanonical", 1, 0, 0);
    issue(64'hC000_0082, 64'h7FFF_FFFF, 0, 0, 0, 0, 0);
    expect_rsp("R8 noncanonical neg", 1, 0, 0);
    issue(64'hC000_0100, 64'hFFFF_8000, 64'h10, 0, 0, 0, 0);
    expect_rsp("R8 canonical high", 0, 1, 0);
    peek("R8 committed", 32'hC000_0100, 64'hFFFF_8000_0000_0010);
    issue(64'hC000_0082, 64'h0000_7FFF, 64'h20, 0, 0, 0, 0);
    expect_rsp("R8 canonical low", 0, 1, 0);
  endtask

  task automatic t_noser;
    issue(64'h6E0, 64'h1, 64'h2, 0, 0, 0, 0);
    expect_rsp("R9 deadline", 0, 0, 0);
    peek("R9 deadline commit", 32'h6E0, 64'h1_0000_0002);
    issue(64'h808, 0, 64'h40, 0, 0, 0, 0);
    expect_rsp("R9 x2 range", 0, 0, 0);
    peek("R9 x2 commit", 32'h808, 64'h40);
  endtask

  task automatic t_mtrr;
    issue(64'h200, 64'h1, 64'h0000_6006, 0, 0, 0, 0);
    expect_rsp("R10 range base", 0, 1, 1);
    issue(64'h201, 0, 64'h800, 0, 0, 0, 0);
    expect_rsp("R10 range mask", 0, 1, 1);
    issue(64'h201, 0, 64'h1, 0, 0, 0, 0);
    expect_rsp("R11 range fault", 1, 0, 0);
    peek("R11 range unchanged", 32'h201, 64'h800);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_basic; t_lock; t_priv; t_v86; t_badidx;
    t_rsvd; t_canon; t_noser; t_mtrr;
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule